// File: doc/BRIEF.md
# Parallel Flash Command Decoder Model

This block is a synthesizable behavioural model of a byte-wide parallel NOR flash device. Its memory array is kept small. The chip-enable, output-enable and write-enable strobes arrive asynchronously and are sampled in the system clock domain. The sampled strobes are decoded into four cases: reads, write (command) cycles, standby and inhibited cycles.

Write cycles are fed to an unlock-sequence tracker. A six-cycle sequence starts a self-timed chip erase, which leaves every byte at FFh. A four-cycle sequence starts a byte program, which can only clear bits.

While an operation runs, the device takes no further commands. During that time a read returns a status byte instead of array data. In the status byte, bit 7 is the complement of the expected final data, and bit 6 inverts on every new read. Array data returns once the operation finishes. The busy lengths are parameters counted in clock cycles, so a bench can measure the busy window.

Top module: `flash_cmd_model`

## Requirements
- R1: While the sampled bus shows ce_n=0, oe_n=0 and we_n=1 (a read), dq_oe is 1. When the device is idle, dq_out carries the array byte at addr[MEM_AW-1:0]. The output register updates on the second rising clk edge after the bus change.
- R2: With ce_n=1 (standby), dq_oe is 0 whatever oe_n and we_n are. With ce_n=0, dq_oe is also 0 when oe_n=1. A cycle in which oe_n or we_n keeps the write condition (ce_n=0, oe_n=1, we_n=0) from being met is not a write and changes no state.
- R3: A write cycle's address and data are taken while ce_n=0, oe_n=1 and we_n=0. The cycle completes, exactly once, when we_n or ce_n rises, whichever rises first.
- R4: Chip erase starts after this write sequence: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h. Sequence addresses are compared on addr[14:0].
- R5: A write cycle that does not match the next expected step returns the tracker to idle, and no operation starts.
- R6: A completed chip erase leaves every array byte at FFh.
- R7: The device is busy for ERASE_CYCLES clock cycles after the final erase cycle completes. During that time every read returns the status byte rather than array data.
- R8: In the status byte, bit 7 is the complement of bit 7 of the operation's final data (0 during an erase), and bits 5:0 are 0.
- R9: Status bit 6 reads 1 on the first read of an operation and inverts on each new read after that.
- R10: Write cycles that complete while the device is busy are ignored.
- R11: Byte program uses the sequence AAh@5555h, 55h@2AAAh, A0h@5555h, then data@address. After PROG_CYCLES clock cycles the addressed byte becomes its old value AND the data.
- R12: During and just after reset, the tracker is idle, dq_oe is 0 and dq_out is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data bus into the device |
| dq_out | output | 8 | Data bus out of the device |
| dq_oe | output | 1 | High while the device drives the data bus |

## Verification
The bench ends a final erase cycle by raising chip enable before write enable. A decoder that waits only for write enable to rise would never erase, or would erase once per strobe.

It corrupts the fifth erase step and checks that later data is untouched. A tracker that skips that step would wipe the array.

It sends a full program sequence in the middle of an erase and checks that the target byte stays FFh. A decoder that keeps taking commands while busy would clear bits there.

It reads status several times in one busy window to catch a bit 6 that never inverts or that changes within a single read. It programs the same byte twice to expose a program path that overwrites the byte instead of only clearing bits.

// File: rtl/flash_model_pkg.sv
`timescale 1ns/1ps
package flash_model_pkg;
    localparam int CMD_AW = 15;

    localparam logic [CMD_AW-1:0] SEQ_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] SEQ_ADDR_B = 15'h2AAA;

    localparam logic [7:0] SEQ_KEY1      = 8'hAA;
    localparam logic [7:0] SEQ_KEY2      = 8'h55;
    localparam logic [7:0] OP_ERASE_ARM  = 8'h80;
    localparam logic [7:0] OP_CHIP_ERASE = 8'h10;
    localparam logic [7:0] OP_PROGRAM    = 8'hA0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_E3,
        ST_E4,
        ST_E5,
        ST_PGM,
        ST_BUSY_ER,
        ST_BUSY_PG
    } seq_state_t;
endpackage

// File: rtl/flash_bus_sampler.sv
`timescale 1ns/1ps
module flash_bus_sampler #(
    parameter int ADDR_W = 15,
    parameter int MEM_AW = 8,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     din,
    output logic              commit,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DW-1:0]     cmd_data,
    output logic              rd_now,
    output logic              rd_start,
    output logic [MEM_AW-1:0] rd_addr
);
    typedef struct packed {
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     din;
        logic              wr_prev;
        logic              rd_prev;
        logic [ADDR_W-1:0] lat_addr;
        logic [DW-1:0]     lat_data;
    } smp_t;

    smp_t st_q, st_d;
    logic wr_now;

    always_comb begin
        wr_now   = !st_q.ce_n && !st_q.we_n && st_q.oe_n;
        rd_now   = !st_q.ce_n && !st_q.oe_n && st_q.we_n;
        rd_start = rd_now && !st_q.rd_prev;
        commit   = st_q.wr_prev && !wr_now;
        cmd_addr = st_q.lat_addr;
        cmd_data = st_q.lat_data;
        rd_addr  = st_q.addr[MEM_AW-1:0];

        st_d         = st_q;
        st_d.ce_n    = ce_n;
        st_d.oe_n    = oe_n;
        st_d.we_n    = we_n;
        st_d.addr    = addr;
        st_d.din     = din;
        st_d.wr_prev = wr_now;
        st_d.rd_prev = rd_now;
        if (wr_now) begin
            st_d.lat_addr = st_q.addr;
            st_d.lat_data = st_q.din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ce_n <= 1'b1;
            st_q.oe_n <= 1'b1;
            st_q.we_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a write that has completed cannot complete again on the next clock
    p_commit_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

// File: rtl/flash_seq_ctrl.sv
`timescale 1ns/1ps
module flash_seq_ctrl
    import flash_model_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int MEM_AW       = 8,
    parameter int ERASE_CYCLES = 64,
    parameter int PROG_CYCLES  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              rd_start,
    output logic              busy,
    output logic              dq7_target,
    output logic              tog,
    output logic              clear_all,
    output logic              prog_we,
    output logic [MEM_AW-1:0] prog_addr,
    output logic [7:0]        prog_data
);
    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PG_LOAD = CNT_W'(PROG_CYCLES - 1);

    typedef struct packed {
        seq_state_t        state;
        logic [CNT_W-1:0]  cnt;
        logic              tog;
        logic [MEM_AW-1:0] paddr;
        logic [7:0]        pdata;
    } ctl_t;

    ctl_t st_q, st_d;
    logic at_a, at_b;

    always_comb begin
        at_a = (cmd_addr[CMD_AW-1:0] == SEQ_ADDR_A);
        at_b = (cmd_addr[CMD_AW-1:0] == SEQ_ADDR_B);

        busy       = (st_q.state == ST_BUSY_ER) || (st_q.state == ST_BUSY_PG);
        dq7_target = (st_q.state == ST_BUSY_PG) ? st_q.pdata[7] : 1'b1;
        tog        = st_q.tog;
        clear_all  = (st_q.state == ST_BUSY_ER) && (st_q.cnt == '0);
        prog_we    = (st_q.state == ST_BUSY_PG) && (st_q.cnt == '0);
        prog_addr  = st_q.paddr;
        prog_data  = st_q.pdata;

        st_d = st_q;
        if (busy) begin
            if (rd_start) st_d.tog = !st_q.tog;
            if (st_q.cnt == '0) st_d.state = ST_IDLE;
            else                st_d.cnt   = st_q.cnt - 1'b1;
        end else if (commit) begin
            st_d.state = ST_IDLE;
            unique case (st_q.state)
                ST_IDLE: if (at_a && cmd_data == SEQ_KEY1) st_d.state = ST_K1;
                ST_K1:   if (at_b && cmd_data == SEQ_KEY2) st_d.state = ST_K2;
                ST_K2: begin
                    if (at_a && cmd_data == OP_ERASE_ARM)    st_d.state = ST_E3;
                    else if (at_a && cmd_data == OP_PROGRAM) st_d.state = ST_PGM;
                end
                ST_E3: if (at_a && cmd_data == SEQ_KEY1) st_d.state = ST_E4;
                ST_E4: if (at_b && cmd_data == SEQ_KEY2) st_d.state = ST_E5;
                ST_E5: begin
                    if (at_a && cmd_data == OP_CHIP_ERASE) begin
                        st_d.state = ST_BUSY_ER;
                        st_d.cnt   = ER_LOAD;
                        st_d.tog   = 1'b0;
                    end
                end
                ST_PGM: begin
                    st_d.state = ST_BUSY_PG;
                    st_d.cnt   = PG_LOAD;
                    st_d.tog   = 1'b0;
                    st_d.paddr = cmd_addr[MEM_AW-1:0];
                    st_d.pdata = cmd_data;
                end
                default: st_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: a write completing inside a busy window leaves the state alone
    p_busy_ignores_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cnt != '0 && commit) |=> (st_q.state == $past(st_q.state)));

    // R7: an erase window always opens with the full count loaded
    p_erase_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.state == ST_BUSY_ER) |-> (st_q.cnt == ER_LOAD));

    // R5: a wrong final erase step drops back to idle
    p_bad_final_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_E5 && commit && cmd_data != OP_CHIP_ERASE) |=> (st_q.state == ST_IDLE));
endmodule

// File: rtl/flash_cell_array.sv
`timescale 1ns/1ps
module flash_cell_array #(
    parameter int MEM_AW = 8,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              prog_we,
    input  logic [MEM_AW-1:0] prog_addr,
    input  logic [DW-1:0]     prog_data,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [DW-1:0] cell_vals [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
        logic [DW-1:0] cell_q, cell_d;
        always_comb begin
            cell_d = cell_q;
            if (clear_all)
                cell_d = '1;
            else if (prog_we && prog_addr == MEM_AW'(gi))
                cell_d = cell_q & prog_data;
        end
        always_ff @(posedge clk) begin
            cell_q <= cell_d;
        end
        assign cell_vals[gi] = cell_q;
    end

    assign rd_data = cell_vals[rd_addr];

    // R6: a clear leaves the first and last rows at all ones
    p_clear_sets_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (cell_vals[0] == '1 && cell_vals[DEPTH-1] == '1));

    // R11: programming only clears bits of the addressed byte
    p_prog_and_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && !clear_all) |=>
        (cell_vals[$past(prog_addr)] == ($past(cell_vals[prog_addr]) & $past(prog_data))));
endmodule

// File: rtl/flash_cmd_model.sv
`timescale 1ns/1ps
module flash_cmd_model #(
    parameter int ADDR_W       = 15,
    parameter int MEM_AW       = 8,
    parameter int ERASE_CYCLES = 64,
    parameter int PROG_CYCLES  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);
    localparam int DW = 8;

    typedef struct packed {
        logic          oe;
        logic [DW-1:0] data;
    } out_t;

    logic              commit, rd_now, rd_start;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DW-1:0]     cmd_data;
    logic [MEM_AW-1:0] rd_addr;
    logic              busy, dq7_target, tog, clear_all, prog_we;
    logic [MEM_AW-1:0] prog_addr;
    logic [DW-1:0]     prog_data, rd_data;

    out_t out_q, out_d;

    flash_bus_sampler #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .DW(DW)) u_sampler (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(dq_in), .commit(commit), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rd_now(rd_now), .rd_start(rd_start), .rd_addr(rd_addr)
    );

    flash_seq_ctrl #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW),
                     .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rd_start(rd_start), .busy(busy),
        .dq7_target(dq7_target), .tog(tog), .clear_all(clear_all),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data)
    );

    flash_cell_array #(.MEM_AW(MEM_AW), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_data(prog_data), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always_comb begin
        out_d = '0;
        if (rd_now) begin
            out_d.oe = 1'b1;
            if (busy)
                out_d.data = {!dq7_target, (rd_start ? !tog : tog), 6'b0};
            else
                out_d.data = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dq_out = out_q.data;
    assign dq_oe  = out_q.oe;

    // R2: no decoded read means the bus is released on the next clock
    p_release_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_now |=> !dq_oe);

    // R1: a decoded read drives the bus on the next clock
    p_drive_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now |=> dq_oe);

    // R8: status byte polarity and unused bits
    p_status_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && busy) |=> (dq_out[5:0] == 6'b0 && dq_out[7] == !$past(dq7_target)));

    // R9: a new read in a busy window shows the inverted toggle state
    p_toggle_new_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && busy) |=> (dq_out[6] != $past(tog)));
endmodule

// File: tb/flash_cmd_model_tb.sv
`timescale 1ns/1ps
module flash_cmd_model_tb;
    localparam int ADDR_W = 15;
    localparam int ER_CYC = 64;
    localparam int PG_CYC = 12;

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read-check, 2 wait (addr = cycles)
        logic [14:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        // R4: chip erase sequence
        '{2'd0, 15'h5555, 8'hAA, 8'h00, 4'd4},
        '{2'd0, 15'h2AAA, 8'h55, 8'h00, 4'd4},
        '{2'd0, 15'h5555, 8'h80, 8'h00, 4'd4},
        '{2'd0, 15'h5555, 8'hAA, 8'h00, 4'd4},
        '{2'd0, 15'h2AAA, 8'h55, 8'h00, 4'd4},
        '{2'd0, 15'h5555, 8'h10, 8'h00, 4'd4},
        // R9: first status read 40h, second 00h
        '{2'd1, 15'h0012, 8'h00, 8'h40, 4'd9},
        '{2'd1, 15'h0012, 8'h00, 8'h00, 4'd9},
        '{2'd2, 15'd90,   8'h00, 8'h00, 4'd7},
        // R6 / R1: erased data
        '{2'd1, 15'h0012, 8'h00, 8'hFF, 4'd6},
        '{2'd1, 15'h00FF, 8'h00, 8'hFF, 4'd1},
        // R11: program 5Ah at 12h
        '{2'd0, 15'h5555, 8'hAA, 8'h00, 4'd11},
        '{2'd0, 15'h2AAA, 8'h55, 8'h00, 4'd11},
        '{2'd0, 15'h5555, 8'hA0, 8'h00, 4'd11},
        '{2'd0, 15'h0012, 8'h5A, 8'h00, 4'd11},
        // R8: program status C0h
        '{2'd1, 15'h0012, 8'h00, 8'hC0, 4'd8},
        '{2'd2, 15'd30,   8'h00, 8'h00, 4'd11},
        '{2'd1, 15'h0012, 8'h00, 8'h5A, 4'd11},
        // R11: two programs at 13h
        '{2'd0, 15'h5555, 8'hAA, 8'h00, 4'd11},
        '{2'd0, 15'h2AAA, 8'h55, 8'h00, 4'd11},
        '{2'd0, 15'h5555, 8'hA0, 8'h00, 4'd11},
        '{2'd0, 15'h0013, 8'h3C, 8'h00, 4'd11},
        '{2'd2, 15'd30,   8'h00, 8'h00, 4'd11},
        '{2'd0, 15'h5555, 8'hAA, 8'h00, 4'd11},
        '{2'd0, 15'h2AAA, 8'h55, 8'h00, 4'd11},
        '{2'd0, 15'h5555, 8'hA0, 8'h00, 4'd11},
        '{2'd0, 15'h0013, 8'hF0, 8'h00, 4'd11},
        '{2'd2, 15'd30,   8'h00, 8'h00, 4'd11},
        '{2'd1, 15'h0013, 8'h00, 8'h30, 4'd11},
        // R5: corrupted fifth step, no erase
        '{2'd0, 15'h5555, 8'hAA, 8'h00, 4'd5},
        '{2'd0, 15'h2AAA, 8'h55, 8'h00, 4'd5},
        '{2'd0, 15'h5555, 8'h80, 8'h00, 4'd5},
        '{2'd0, 15'h5555, 8'hAA, 8'h00, 4'd5},
        '{2'd0, 15'h2AAA, 8'h56, 8'h00, 4'd5},
        '{2'd0, 15'h5555, 8'h10, 8'h00, 4'd5},
        '{2'd1, 15'h0012, 8'h00, 8'h5A, 4'd5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic dq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_model #(.ADDR_W(ADDR_W), .MEM_AW(8), .ERASE_CYCLES(ER_CYC),
                      .PROG_CYCLES(PG_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [14:0] a, input logic [7:0] d,
                             input bit ce_first, input bit inhibit);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = 1'b0; oe_n = inhibit ? 1'b0 : 1'b1; we_n = 1'b0;
        repeat (2) @(negedge clk);
        if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic [14:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (2) @(negedge clk);
        d = dq_out; oe = dq_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic erase_seq(input bit ce_first);
        bus_write(15'h5555, 8'hAA, 1'b0, 1'b0);
        bus_write(15'h2AAA, 8'h55, 1'b0, 1'b0);
        bus_write(15'h5555, 8'h80, 1'b0, 1'b0);
        bus_write(15'h5555, 8'hAA, 1'b0, 1'b0);
        bus_write(15'h2AAA, 8'h55, 1'b0, 1'b0);
        bus_write(15'h5555, 8'h10, ce_first, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic roe;

        // R12: reset state
        repeat (4) @(negedge clk);
        chk("R12 dq_oe in reset", {7'b0, dq_oe}, 8'h00);
        chk("R12 dq_out in reset", dq_out, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 dq_oe after reset", {7'b0, dq_oe}, 8'h00);

        // vector table
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: bus_write(VECS[i].addr, VECS[i].data, 1'b0, 1'b0);
                2'd1: begin
                    bus_read(VECS[i].addr, rd, roe);
                    chk($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
                end
                default: repeat (int'(VECS[i].addr)) @(negedge clk);
            endcase
        end

        // R2: standby with oe_n low, and oe_n high while selected
        @(negedge clk);
        addr = 15'h0012; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 standby dq_oe", {7'b0, dq_oe}, 8'h00);
        ce_n = 1'b0; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 oe_n high dq_oe", {7'b0, dq_oe}, 8'h00);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: inhibited program cycles do nothing (13h holds 30h)
        bus_write(15'h5555, 8'hAA, 1'b0, 1'b1);
        bus_write(15'h2AAA, 8'h55, 1'b0, 1'b1);
        bus_write(15'h5555, 8'hA0, 1'b0, 1'b1);
        bus_write(15'h0013, 8'h00, 1'b0, 1'b1);
        repeat (30) @(negedge clk);
        bus_read(15'h0013, rd, roe);
        chk("R2 inhibited program", rd, 8'h30);

        // R3 / R7 / R9 / R10: erase ended by ce_n first, commands ignored while busy
        erase_seq(1'b1);
        bus_read(15'h0012, rd, roe);
        chk("R9 first status read", rd, 8'h40);
        bus_write(15'h5555, 8'hAA, 1'b0, 1'b0);
        bus_write(15'h2AAA, 8'h55, 1'b0, 1'b0);
        bus_write(15'h5555, 8'hA0, 1'b0, 1'b0);
        bus_write(15'h0012, 8'h00, 1'b0, 1'b0);
        bus_read(15'h0012, rd, roe);
        chk("R9 second status read", rd, 8'h00);
        bus_read(15'h0012, rd, roe);
        chk("R9 third status read", rd, 8'h40);
        chk("R7 status while busy drives bus", {7'b0, roe}, 8'h01);
        repeat (ER_CYC + 10) @(negedge clk);
        bus_read(15'h0012, rd, roe);
        chk("R10 command during erase ignored", rd, 8'hFF);
        bus_read(15'h0013, rd, roe);
        chk("R3 erase started by ce_n rise", rd, 8'hFF);

        // R7: busy window edges
        erase_seq(1'b0);
        repeat (ER_CYC - 20) @(negedge clk);
        bus_read(15'h0013, rd, roe);
        chk("R7 still busy near window end", rd, 8'h40);
        repeat (20) @(negedge clk);
        bus_read(15'h0013, rd, roe);
        chk("R7 data after window", rd, 8'hFF);

        finish_run();
    end
endmodule